// File: doc/BRIEF.md
# Shared Chunk Packet Buffer

This block is the central holding store for a switch whose crossbar turns a packet away, either because the wanted output is already sending or because the input lost the least-recently-served contest for it. Such packets are written here one byte at a time, each with a destination output index. Storage is one pool of fixed 8-byte chunks shared by all outputs. Chunks are taken from a linked free list as bytes arrive. Each chunk is appended to a linked chain kept for the packet's destination.

When an output becomes free, the surrounding logic asks for bytes for that output. The block returns the oldest stored packet for that output one byte per request, and flags the packet's final byte. A chunk goes back to the free list as soon as its last byte has been read. No output owns any part of the storage, so one busy output may use most of the pool while the others use little. Choosing between buffered packets and fresh crossbar traffic is left to the logic outside.

Top module: `chunk_pkt_buffer`

## Requirements
- R1: After reset every `q_empty` bit is 1, `pool_full` is 0, `wr_ready` is 1 and `rd_valid` is 0.
- R2: A byte is stored on a clock edge where `wr_valid` and `wr_ready` are both 1. The destination is taken from `wr_dest` at the first byte of a packet and is kept until the byte carrying `wr_last` = 1, which ends the packet.
- R3: When `rd_en` = 1 and the `q_empty` bit selected by `rd_dest` is 0, the next stored byte for that output appears on `rd_data` with `rd_valid` = 1 in the following cycle. `rd_last` = 1 comes with the packet's final byte.
- R4: For any one output, packets are read back in the order in which they were written, with their bytes in write order.
- R5: `rd_en` aimed at an output whose `q_empty` bit is 1 is ignored: `rd_valid` stays 0 in the next cycle and no stored byte is consumed.
- R6: Packets for different outputs may interleave in the pool. Reading one output never alters the content or order of packets held for another output.
- R7: The pool has 16 chunks of 8 bytes. Every packet starts in a fresh chunk and takes ceil(length/8) chunks. `pool_full` is 1 exactly when no chunk is free.
- R8: `wr_ready` is 0 only when the next byte needs a new chunk (the first byte of a packet, or the byte after 8 bytes of a chunk) and no chunk is free. Bytes that land inside an already taken chunk are always accepted.
- R9: A chunk returns to the free list in the cycle its final byte is read (its eighth byte, or the packet's last byte). From the next cycle `pool_full` is clear and a waiting write is accepted.
- R10: The `q_empty` bit of an output goes to 0 only after the `wr_last` byte of a packet for it has been accepted. It goes back to 1 once its last complete packet has been fully read.
- R11: A write and a read may happen in the same cycle, including to and from the same output, without corrupting either packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte offered on the write side |
| wr_ready | output | 1 | Write side can take a byte this cycle |
| wr_data | input | 8 | Byte to store |
| wr_last | input | 1 | Byte is the final byte of its packet |
| wr_dest | input | 2 | Destination output, sampled at the packet's first byte |
| rd_en | input | 1 | Request the next byte for output `rd_dest` |
| rd_dest | input | 2 | Output being drained |
| rd_valid | output | 1 | `rd_data` holds a byte returned for last cycle's request |
| rd_data | output | 8 | Returned byte |
| rd_last | output | 1 | Returned byte ends its packet |
| q_empty | output | 4 | One bit per output, 1 when no complete packet is stored for it |
| pool_full | output | 1 | No free chunk is left |

## Verification
A write is taken on the edge where `wr_valid` and `wr_ready` are both high. Its effect on `q_empty` and `pool_full` can be seen from the next falling edge. A read request registered on one rising edge presents its byte on `rd_valid`, `rd_data` and `rd_last` until the following rising edge. `wr_ready` is formed only from registered state, so a chunk freed by a read shows up as `wr_ready` one cycle after that read. The bench drives every input on the falling edge. It takes the write handshake from `wr_ready` sampled just after that edge, and it checks read results on the falling edge that follows each request, which is the one cycle at which they are due.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

  // A chunk closes when its final slot is filled/drained or the packet ends.
  function automatic logic chunk_done(input int unsigned off, input int unsigned cb,
                                      input logic last);
    return last || (off == cb - 1);
  endfunction

  // Up/down counter step.
  function automatic int unsigned step_count(input int unsigned cur, input logic up,
                                             input logic down);
    return cur + (up ? 1 : 0) - (down ? 1 : 0);
  endfunction

endpackage

// File: rtl/sbuf_byte_store.sv
module sbuf_byte_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 128,
  parameter int AW     = 7
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [DATA_W:0] wdata,
  input  logic [AW-1:0]   raddr,
  output logic [DATA_W:0] rdata
);
  // Each entry: {end_of_packet, byte}
  logic [DATA_W:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sbuf_next_table.sv
module sbuf_next_table #(
  parameter int N  = 16,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic [CW-1:0] a_idx,
  input  logic [CW-1:0] a_val,
  input  logic          b_we,
  input  logic [CW-1:0] b_idx,
  input  logic [CW-1:0] b_val,
  input  logic [CW-1:0] r0_idx,
  output logic [CW-1:0] r0_val,
  input  logic [CW-1:0] r1_idx,
  output logic [CW-1:0] r1_val
);
  logic [CW-1:0] nxt [N];

  // At reset every chunk is chained to its successor: the initial free list.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) nxt[i] <= CW'((i + 1) % N);
    end else begin
      if (a_we) nxt[a_idx] <= a_val;
      if (b_we) nxt[b_idx] <= b_val;  // free-list link wins on a clash
    end
  end

  assign r0_val = nxt[r0_idx];
  assign r1_val = nxt[r1_idx];
endmodule

// File: rtl/sbuf_free_list.sv
module sbuf_free_list #(
  parameter int N    = 16,
  parameter int CW   = 4,
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            give,
  input  logic [CW-1:0]   give_idx,
  input  logic [CW-1:0]   head_next,
  output logic [CW-1:0]   free_head,
  output logic [CNTW-1:0] free_cnt,
  output logic            link_we,
  output logic [CW-1:0]   link_idx,
  output logic [CW-1:0]   link_val
);
  // A returned chunk becomes the new head; it points past the chunk
  // being taken in the same cycle, if any.
  assign link_we  = give;
  assign link_idx = give_idx;
  assign link_val = take ? head_next : free_head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_head <= '0;
      free_cnt  <= CNTW'(N);
    end else begin
      if (give)      free_head <= give_idx;
      else if (take) free_head <= head_next;
      free_cnt <= CNTW'(sbuf_pkg::step_count(free_cnt, give, take));
    end
  end
endmodule

// File: rtl/sbuf_out_queue.sv
module sbuf_out_queue #(
  parameter int CW   = 4,
  parameter int OFFW = 3,
  parameter int CNTW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            alloc_hit,
  input  logic [CW-1:0]   new_chunk,
  input  logic            free_hit,
  input  logic [CW-1:0]   head_after,
  input  logic            pkt_in,
  input  logic            pkt_out,
  input  logic            rd_step,
  output logic [CW-1:0]   head,
  output logic [CW-1:0]   tail,
  output logic [CNTW-1:0] nchk,
  output logic [CNTW-1:0] pkt_cnt,
  output logic [OFFW-1:0] rd_off
);
  logic chain_void;
  // After this cycle's release, does the chain hold no chunk at all?
  assign chain_void = (nchk == '0) || (free_hit && nchk == CNTW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      nchk    <= '0;
      pkt_cnt <= '0;
      rd_off  <= '0;
    end else begin
      if (alloc_hit && chain_void) head <= new_chunk;
      else if (free_hit)           head <= head_after;
      if (alloc_hit) tail <= new_chunk;
      nchk    <= CNTW'(sbuf_pkg::step_count(nchk, alloc_hit, free_hit));
      pkt_cnt <= CNTW'(sbuf_pkg::step_count(pkt_cnt, pkt_in, pkt_out));
      if (rd_step) rd_off <= free_hit ? '0 : rd_off + OFFW'(1);
    end
  end
endmodule

// File: rtl/chunk_pkt_buffer.sv
module chunk_pkt_buffer #(
  parameter int NUM_OUT     = 4,
  parameter int CHUNK_BYTES = 8,
  parameter int NUM_CHUNKS  = 16,
  parameter int DATA_W      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_last,
  input  logic [$clog2(NUM_OUT)-1:0] wr_dest,
  input  logic               rd_en,
  input  logic [$clog2(NUM_OUT)-1:0] rd_dest,
  output logic               rd_valid,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_last,
  output logic [NUM_OUT-1:0] q_empty,
  output logic               pool_full
);
  localparam int OW   = $clog2(NUM_OUT);
  localparam int CW   = $clog2(NUM_CHUNKS);
  localparam int OFFW = $clog2(CHUNK_BYTES);
  localparam int AW   = CW + OFFW;
  localparam int CNTW = $clog2(NUM_CHUNKS + 1);

  // Write-side state
  logic [OFFW-1:0] wr_off;
  logic [CW-1:0]   wr_chunk;
  logic            in_pkt;
  logic [OW-1:0]   pkt_dest;

  // Named internal events (observed by the checker)
  logic            alloc_fire, free_fire, rd_fire, wr_fire;
  logic [OW-1:0]   dest_eff;
  logic            need_chunk;
  logic [CW-1:0]   free_head;
  logic [CNTW-1:0] free_cnt;
  logic [CW-1:0]   head_next_free, head_next_rd;
  logic [CW-1:0]   wchunk_eff;
  logic [DATA_W:0] rd_entry;
  logic            link_tail;

  // Per-output queue state
  logic [CW-1:0]   q_head   [NUM_OUT];
  logic [CW-1:0]   q_tail   [NUM_OUT];
  logic [CNTW-1:0] q_nchk   [NUM_OUT];
  logic [CNTW-1:0] q_pkts   [NUM_OUT];
  logic [OFFW-1:0] q_rd_off [NUM_OUT];
  logic [NUM_OUT*CNTW-1:0] nchk_flat;

  logic [CW-1:0]   rhead;
  logic [OFFW-1:0] roff;
  logic            ent_last;
  logic            fl_link_we;
  logic [CW-1:0]   fl_link_idx, fl_link_val;

  // ---------------- write side ----------------
  assign dest_eff   = in_pkt ? pkt_dest : wr_dest;
  assign need_chunk = (wr_off == '0);
  assign pool_full  = (free_cnt == '0);
  assign wr_ready   = !(need_chunk && pool_full);
  assign wr_fire    = wr_valid && wr_ready;
  assign alloc_fire = wr_fire && need_chunk;
  assign wchunk_eff = need_chunk ? free_head : wr_chunk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_off   <= '0;
      wr_chunk <= '0;
      in_pkt   <= 1'b0;
      pkt_dest <= '0;
    end else if (wr_fire) begin
      wr_off   <= sbuf_pkg::chunk_done(wr_off, CHUNK_BYTES, wr_last) ? '0 : wr_off + OFFW'(1);
      wr_chunk <= wchunk_eff;
      in_pkt   <= !wr_last;
      if (!in_pkt) pkt_dest <= wr_dest;
    end
  end

  // ---------------- read side ----------------
  assign rhead     = q_head[rd_dest];
  assign roff      = q_rd_off[rd_dest];
  assign rd_fire   = rd_en && (q_pkts[rd_dest] != '0);
  assign ent_last  = rd_entry[DATA_W];
  assign free_fire = rd_fire && sbuf_pkg::chunk_done(roff, CHUNK_BYTES, ent_last);

  // Link the new chunk behind the tail only if the chain still holds one
  // after this cycle's release.
  assign link_tail = alloc_fire &&
                     !((q_nchk[dest_eff] == '0) ||
                       (free_fire && rd_dest == dest_eff && q_nchk[dest_eff] == CNTW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_last  <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        rd_data <= rd_entry[DATA_W-1:0];
        rd_last <= ent_last;
      end
    end
  end

  // ---------------- storage ----------------
  sbuf_byte_store #(.DATA_W(DATA_W), .DEPTH(NUM_CHUNKS * CHUNK_BYTES), .AW(AW)) u_store (
    .clk   (clk),
    .we    (wr_fire),
    .waddr ({wchunk_eff, wr_off}),
    .wdata ({wr_last, wr_data}),
    .raddr ({rhead, roff}),
    .rdata (rd_entry)
  );

  sbuf_next_table #(.N(NUM_CHUNKS), .CW(CW)) u_next (
    .clk    (clk),
    .rst_n  (rst_n),
    .a_we   (link_tail),
    .a_idx  (q_tail[dest_eff]),
    .a_val  (free_head),
    .b_we   (fl_link_we),
    .b_idx  (fl_link_idx),
    .b_val  (fl_link_val),
    .r0_idx (free_head),
    .r0_val (head_next_free),
    .r1_idx (rhead),
    .r1_val (head_next_rd)
  );

  sbuf_free_list #(.N(NUM_CHUNKS), .CW(CW), .CNTW(CNTW)) u_free (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (alloc_fire),
    .give      (free_fire),
    .give_idx  (rhead),
    .head_next (head_next_free),
    .free_head (free_head),
    .free_cnt  (free_cnt),
    .link_we   (fl_link_we),
    .link_idx  (fl_link_idx),
    .link_val  (fl_link_val)
  );

  // ---------------- one chain per output ----------------
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    logic sel_w, sel_r;
    assign sel_w = (dest_eff == OW'(g));
    assign sel_r = (rd_dest == OW'(g));

    sbuf_out_queue #(.CW(CW), .OFFW(OFFW), .CNTW(CNTW)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .alloc_hit  (alloc_fire && sel_w),
      .new_chunk  (free_head),
      .free_hit   (free_fire && sel_r),
      .head_after (head_next_rd),
      .pkt_in     (wr_fire && wr_last && sel_w),
      .pkt_out    (rd_fire && ent_last && sel_r),
      .rd_step    (rd_fire && sel_r),
      .head       (q_head[g]),
      .tail       (q_tail[g]),
      .nchk       (q_nchk[g]),
      .pkt_cnt    (q_pkts[g]),
      .rd_off     (q_rd_off[g])
    );

    assign q_empty[g] = (q_pkts[g] == '0);
    assign nchk_flat[g*CNTW +: CNTW] = q_nchk[g];
  end
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk #(
  parameter int NUM_OUT    = 4,
  parameter int NUM_CHUNKS = 16
) (
  input logic clk,
  input logic rst_n,
  input logic alloc_fire,
  input logic free_fire,
  input logic rd_fire,
  input logic rd_en,
  input logic [$clog2(NUM_OUT)-1:0] rd_dest,
  input logic [NUM_OUT-1:0] q_empty,
  input logic rd_valid,
  input logic [$clog2(NUM_CHUNKS+1)-1:0] free_cnt,
  input logic [NUM_OUT*$clog2(NUM_CHUNKS+1)-1:0] nchk_flat
);
  localparam int CNTW = $clog2(NUM_CHUNKS + 1);

  function automatic int chained_total(input logic [NUM_OUT*CNTW-1:0] v);
    int s = 0;
    for (int i = 0; i < NUM_OUT; i++) s += int'(v[i*CNTW +: CNTW]);
    return s;
  endfunction

  // R8
  alloc_needs_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> free_cnt != '0);

  // R7
  chunk_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(free_cnt) + chained_total(nchk_flat) == NUM_CHUNKS);

  // R3
  rd_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_fire));

  // R5
  empty_read_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && q_empty[rd_dest]) |=> !rd_valid);

  // R9
  free_count_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_fire && !free_fire) |=> $stable(free_cnt));
endmodule

bind chunk_pkt_buffer sbuf_chk #(.NUM_OUT(NUM_OUT), .NUM_CHUNKS(NUM_CHUNKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_fire (alloc_fire),
  .free_fire  (free_fire),
  .rd_fire    (rd_fire),
  .rd_en      (rd_en),
  .rd_dest    (rd_dest),
  .q_empty    (q_empty),
  .rd_valid   (rd_valid),
  .free_cnt   (free_cnt),
  .nchk_flat  (nchk_flat)
);

// File: tb/chunk_pkt_buffer_tb.sv
module chunk_pkt_buffer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic       wr_last = 1'b0;
  logic [1:0] wr_dest = '0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_dest = '0;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_last;
  logic [3:0] q_empty;
  logic       pool_full;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  chunk_pkt_buffer u_dut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .wr_last(wr_last), .wr_dest(wr_dest),
    .rd_en(rd_en), .rd_dest(rd_dest), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_last(rd_last),
    .q_empty(q_empty), .pool_full(pool_full)
  );

  typedef struct packed {
    logic [1:0] dest;
    logic [7:0] len;
    logic [7:0] base;
  } vec_t;

  // Interleaved packets over all outputs: 1+1+2+1+2+1 = 8 chunks.
  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 8'd5,  8'h10},
    '{2'd1, 8'd8,  8'h20},
    '{2'd0, 8'd9,  8'h30},
    '{2'd2, 8'd1,  8'h40},
    '{2'd3, 8'd16, 8'h50},
    '{2'd1, 8'd3,  8'h70}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  // Sends bytes [from, from+cnt) of a packet of 'len' bytes starting at 'base'.
  task automatic send_part(input int dest, input int base, input int from,
                           input int cnt, input int len);
    for (int i = from; i < from + cnt; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_dest  = 2'(dest);
      wr_data  = 8'(base + i);
      wr_last  = (i == len - 1);
      #1;
      while (!wr_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    wr_valid = 1'b0;
    wr_last  = 1'b0;
  endtask

  task automatic send_pkt(input int dest, input int len, input int base);
    send_part(dest, base, 0, len, len);
  endtask

  task automatic read_pkt(input int dest, input int len, input int base, input string req);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rd_en   = 1'b1;
      rd_dest = 2'(dest);
      @(negedge clk);
      rd_en = 1'b0;
      chk(rd_valid === 1'b1, req, "rd_valid", int'(rd_valid), 1);
      chk(rd_data === 8'(base + i), req, "rd_data", int'(rd_data), (base + i) % 256);
      chk(rd_last === (i == len - 1), req, "rd_last", int'(rd_last), int'(i == len - 1));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(q_empty === 4'hF, "R1", "q_empty", int'(q_empty), 15);
    chk(pool_full === 1'b0, "R1", "pool_full", int'(pool_full), 0);
    chk(wr_ready === 1'b1, "R1", "wr_ready", int'(wr_ready), 1);
    chk(rd_valid === 1'b0, "R1", "rd_valid", int'(rd_valid), 0);

    // Table walk: R2, R4, R6, R10
    for (int k = 0; k < NV; k++) send_pkt(VEC[k].dest, VEC[k].len, VEC[k].base);
    chk(q_empty === 4'h0, "R10", "q_empty after writes", int'(q_empty), 0);
    chk(pool_full === 1'b0, "R7", "pool_full at 8 chunks", int'(pool_full), 0);
    for (int k = NV - 1; k >= 0; k--) begin
      // Read in table order per output; drain outputs high index first (R6).
      if (VEC[k].dest == 2'd3) read_pkt(3, VEC[k].len, VEC[k].base, "R6");
    end
    for (int k = 0; k < NV; k++)
      if (VEC[k].dest != 2'd3) read_pkt(VEC[k].dest, VEC[k].len, VEC[k].base, "R4");
    chk(q_empty === 4'hF, "R10", "q_empty after drain", int'(q_empty), 15);

    // Fill 15 chunks with 8-byte packets for output 0 (R7)
    for (int p = 0; p < 15; p++) send_pkt(0, 8, p * 16);
    chk(pool_full === 1'b0, "R7", "pool_full at 15 chunks", int'(pool_full), 0);

    // R5: read of an empty output is ignored
    @(negedge clk);
    rd_en   = 1'b1;
    rd_dest = 2'd2;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_valid === 1'b0, "R5", "rd_valid on empty", int'(rd_valid), 0);
    chk(q_empty[2] === 1'b1, "R5", "q_empty[2]", int'(q_empty[2]), 1);

    // R8: 12-byte packet to output 3 takes the last chunk, then stalls
    send_part(3, 8'hF0, 0, 8, 12);
    chk(pool_full === 1'b1, "R7", "pool_full at 16 chunks", int'(pool_full), 1);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_dest  = 2'd1;  // must be ignored mid-packet (R2)
    wr_data  = 8'hF8;
    #1;
    chk(wr_ready === 1'b0, "R8", "wr_ready at boundary, pool empty", int'(wr_ready), 1'b0);
    repeat (3) @(negedge clk);
    chk(wr_ready === 1'b0, "R8", "wr_ready still held", int'(wr_ready), 0);
    wr_valid = 1'b0;
    chk(q_empty[3] === 1'b1, "R10", "q_empty[3] while incomplete", int'(q_empty[3]), 1);

    // R9: draining one packet frees its chunk
    read_pkt(0, 8, 0, "R4");
    chk(pool_full === 1'b0, "R9", "pool_full after free", int'(pool_full), 0);
    chk(wr_ready === 1'b1, "R9", "wr_ready after free", int'(wr_ready), 1);
    send_part(1, 8'hF0, 8, 4, 12);
    chk(q_empty[3] === 1'b0, "R10", "q_empty[3] after last", int'(q_empty[3]), 0);
    chk(q_empty[1] === 1'b1, "R2", "q_empty[1] untouched", int'(q_empty[1]), 1);
    read_pkt(3, 12, 8'hF0, "R2");
    for (int p = 1; p < 15; p++) read_pkt(0, 8, p * 16, "R4");
    chk(q_empty === 4'hF, "R10", "q_empty after second drain", int'(q_empty), 15);

    // R11: write and read on the same output at once
    send_pkt(1, 3, 8'h40);
    fork
      send_pkt(1, 10, 8'h50);
      read_pkt(1, 3, 8'h40, "R11");
    join
    read_pkt(1, 10, 8'h50, "R11");
    chk(q_empty === 4'hF, "R11", "q_empty at end", int'(q_empty), 15);
    chk(pool_full === 1'b0, "R9", "pool_full at end", int'(pool_full), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule